// File: doc/BRIEF.md
# Multi-Page-Size Address Translation Buffer

This block is a fully associative translation buffer. It maps virtual page numbers to physical frame numbers, and entries of different page sizes share one array. Each entry stores a 2-bit size code. The code decides how many virtual address bits take part in the tag compare and how many low address bits pass straight through to the physical address.

A lookup port takes a 43-bit virtual address. In the same cycle it returns a hit flag, a 34-bit physical address and separate read and write permission bits. Misses are resolved by privileged software, which walks its own tables and then writes one entry through the fill port. The block does no table walking. Fills are placed by a round-robin pointer. Two invalidate controls exist: one drops every entry matching a given page, and the other flushes the whole array. A lookup that matches more than one entry raises a multiple-hit flag and is reported as a miss.

Top module: `mpsz_tlb`

## Requirements
- R1: After reset the array holds no valid entry. Every lookup reports hit_o=0, multi_hit_o=0, pa_o=0, rd_ok_o=0 and wr_ok_o=0.
- R2: The size code sets which VA bits an entry compares: 00 (8 KB) compares VA[42:13], 01 (64 KB) compares VA[42:16], 10 (512 KB) compares VA[42:19] and 11 (4 MB) compares VA[42:22]. A lookup in the next page up misses.
- R3: On a hit, pa_o bits below the page boundary (13, 16, 19 or 22 for codes 00..11) are copied from the lookup VA. The bits at and above the boundary come from the entry's frame number, where frame bit k is PA bit 13+k. Frame bits that fall under the offset are ignored.
- R4: rd_ok_o and wr_ok_o report the hit entry's read and write permission bits independently of each other.
- R5: On a miss, pa_o, rd_ok_o and wr_ok_o are all zero.
- R6: The lookup is combinational. A fill is invisible to a lookup in its own cycle and visible in every following cycle.
- R7: Fills go to entries 0, 1, …, N_ENTRIES-1 and then wrap to 0. With 32 entries, the 33rd fill after a flush evicts the first. The pointer moves only on a fill.
- R8: When more than one valid entry matches, multi_hit_o=1 and hit_o=0, and the lookup counts as a miss.
- R9: inv_all_i clears every valid bit in one cycle and returns the fill pointer to entry 0. A fill in the same cycle is dropped.
- R10: inv_one_i clears every entry that matches inv_vpn_i, each under its own size mask, and leaves the other entries alone. A fill in the same cycle is still written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_va_i | input | 43 | Lookup virtual address |
| hit_o | output | 1 | Exactly one entry matched |
| multi_hit_o | output | 1 | More than one entry matched |
| pa_o | output | 34 | Translated physical address |
| rd_ok_o | output | 1 | Read permitted by hit entry |
| wr_ok_o | output | 1 | Write permitted by hit entry |
| fill_i | input | 1 | Write one entry at the replacement pointer |
| fill_vpn_i | input | 30 | Virtual page number (VA[42:13]) of the fill |
| fill_pfn_i | input | 21 | Frame number (PA[33:13]) of the fill |
| fill_size_i | input | 2 | Page size code of the fill |
| fill_rd_i | input | 1 | Read permission of the fill |
| fill_wr_i | input | 1 | Write permission of the fill |
| inv_one_i | input | 1 | Invalidate entries matching inv_vpn_i |
| inv_vpn_i | input | 30 | Virtual page number (VA[42:13]) to invalidate |
| inv_all_i | input | 1 | Flush all entries |

## Verification
The clocked properties assume that the lookup address and the control inputs are known and hold steady around each rising edge. The stimulus therefore changes every input on the falling edge only. The offset and miss-zero properties also assume that a hit can only come from a valid entry. The random phase draws addresses from a handful of 4 MB regions, so overlapping fills of different sizes and genuine multiple hits occur often. Flushes are kept rare so that the replacement pointer wraps many times between them.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    PG_8K   = 2'b00,
    PG_64K  = 2'b01,
    PG_512K = 2'b10,
    PG_4M   = 2'b11
  } pg_size_e;

  // each size step widens the page offset by this many bits
  localparam int unsigned LVL_STEP = 3;

  function automatic int unsigned pg_extra_bits(pg_size_e s);
    return LVL_STEP * 32'(s);
  endfunction

endpackage

// File: rtl/tlb_match.sv
module tlb_match
  import tlb_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 32,
  parameter int unsigned VPN_W     = 30
) (
  input  logic [N_ENTRIES-1:0] valid_i,
  input  logic [VPN_W-1:0]     tag_i  [N_ENTRIES],
  input  pg_size_e             size_i [N_ENTRIES],
  input  logic [VPN_W-1:0]     key_i,
  output logic [N_ENTRIES-1:0] match_o
);

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
    logic [VPN_W-1:0] care;
    assign care       = {VPN_W{1'b1}} << pg_extra_bits(size_i[g]);
    assign match_o[g] = valid_i[g] & ~|((tag_i[g] ^ key_i) & care);
  end

endmodule

// File: rtl/tlb_read_mux.sv
module tlb_read_mux
  import tlb_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 32,
  parameter int unsigned PFN_W     = 21
) (
  input  logic [N_ENTRIES-1:0] match_i,
  input  logic [PFN_W-1:0]     pfn_i  [N_ENTRIES],
  input  pg_size_e             size_i [N_ENTRIES],
  input  logic [N_ENTRIES-1:0] rd_i,
  input  logic [N_ENTRIES-1:0] wr_i,
  input  logic [PFN_W-1:0]     key_i,
  output logic                 hit_o,
  output logic                 multi_o,
  output logic [PFN_W-1:0]     frame_o,
  output logic                 rd_o,
  output logic                 wr_o
);

  logic [PFN_W-1:0] merged [N_ENTRIES];

  // low frame bits of larger pages come from the lookup address
  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_merge
    logic [PFN_W-1:0] keep;
    assign keep      = {PFN_W{1'b1}} << pg_extra_bits(size_i[g]);
    assign merged[g] = (pfn_i[g] & keep) | (key_i & ~keep);
  end

  // more than one bit set
  assign multi_o = |(match_i & (match_i - N_ENTRIES'(1)));
  assign hit_o   = |match_i & ~multi_o;

  always_comb begin
    frame_o = '0;
    rd_o    = 1'b0;
    wr_o    = 1'b0;
    if (hit_o) begin
      for (int e = 0; e < N_ENTRIES; e++) begin
        if (match_i[e]) begin
          frame_o = frame_o | merged[e];
          rd_o    = rd_o | rd_i[e];
          wr_o    = wr_o | wr_i[e];
        end
      end
    end
  end

endmodule

// File: rtl/tlb_rr_ptr.sv
module tlb_rr_ptr #(
  parameter int unsigned N_ENTRIES = 32,
  localparam int unsigned IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             adv_i,
  output logic [IDX_W-1:0] ptr_o
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENTRIES - 1);

  logic [IDX_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ptr_q <= '0;
    else if (clear_i)  ptr_q <= '0;
    else if (adv_i)    ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  assign ptr_o = ptr_q;

endmodule

// File: rtl/mpsz_tlb.sv
module mpsz_tlb
  import tlb_pkg::*;
#(
  parameter int unsigned N_ENTRIES  = 32,
  parameter int unsigned VA_W       = 43,
  parameter int unsigned PA_W       = 34,
  parameter int unsigned BASE_SHIFT = 13,
  localparam int unsigned VPN_W = VA_W - BASE_SHIFT,
  localparam int unsigned PFN_W = PA_W - BASE_SHIFT,
  localparam int unsigned IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [VA_W-1:0]  lk_va_i,
  output logic             hit_o,
  output logic             multi_hit_o,
  output logic [PA_W-1:0]  pa_o,
  output logic             rd_ok_o,
  output logic             wr_ok_o,
  input  logic             fill_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [PFN_W-1:0] fill_pfn_i,
  input  logic [1:0]       fill_size_i,
  input  logic             fill_rd_i,
  input  logic             fill_wr_i,
  input  logic             inv_one_i,
  input  logic [VPN_W-1:0] inv_vpn_i,
  input  logic             inv_all_i
);

  logic [N_ENTRIES-1:0] valid_q;
  logic [VPN_W-1:0]     tag_q  [N_ENTRIES];
  logic [PFN_W-1:0]     pfn_q  [N_ENTRIES];
  pg_size_e             size_q [N_ENTRIES];
  logic [N_ENTRIES-1:0] rd_q;
  logic [N_ENTRIES-1:0] wr_q;

  logic [N_ENTRIES-1:0] lk_match;
  logic [N_ENTRIES-1:0] inv_match;
  logic [IDX_W-1:0]     rr_ptr;
  logic                 fill_en;
  logic                 mux_hit;
  logic [PFN_W-1:0]     mux_frame;
  logic                 mux_rd;
  logic                 mux_wr;

  assign fill_en = fill_i & ~inv_all_i;

  tlb_rr_ptr #(.N_ENTRIES(N_ENTRIES)) i_rr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (inv_all_i),
    .adv_i   (fill_en),
    .ptr_o   (rr_ptr)
  );

  tlb_match #(.N_ENTRIES(N_ENTRIES), .VPN_W(VPN_W)) i_lk_match (
    .valid_i (valid_q),
    .tag_i   (tag_q),
    .size_i  (size_q),
    .key_i   (lk_va_i[VA_W-1:BASE_SHIFT]),
    .match_o (lk_match)
  );

  tlb_match #(.N_ENTRIES(N_ENTRIES), .VPN_W(VPN_W)) i_inv_match (
    .valid_i (valid_q),
    .tag_i   (tag_q),
    .size_i  (size_q),
    .key_i   (inv_vpn_i),
    .match_o (inv_match)
  );

  tlb_read_mux #(.N_ENTRIES(N_ENTRIES), .PFN_W(PFN_W)) i_mux (
    .match_i (lk_match),
    .pfn_i   (pfn_q),
    .size_i  (size_q),
    .rd_i    (rd_q),
    .wr_i    (wr_q),
    .key_i   (lk_va_i[BASE_SHIFT+PFN_W-1:BASE_SHIFT]),
    .hit_o   (mux_hit),
    .multi_o (multi_hit_o),
    .frame_o (mux_frame),
    .rd_o    (mux_rd),
    .wr_o    (mux_wr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      rd_q    <= '0;
      wr_q    <= '0;
      for (int e = 0; e < N_ENTRIES; e++) begin
        tag_q[e]  <= '0;
        pfn_q[e]  <= '0;
        size_q[e] <= PG_8K;
      end
    end else if (inv_all_i) begin
      valid_q <= '0;
    end else begin
      // single invalidate first, a same-cycle fill overrides its slot
      valid_q <= valid_q & ~(inv_match & {N_ENTRIES{inv_one_i}});
      if (fill_i) begin
        valid_q[rr_ptr] <= 1'b1;
        tag_q[rr_ptr]   <= fill_vpn_i;
        pfn_q[rr_ptr]   <= fill_pfn_i;
        size_q[rr_ptr]  <= pg_size_e'(fill_size_i);
        rd_q[rr_ptr]    <= fill_rd_i;
        wr_q[rr_ptr]    <= fill_wr_i;
      end
    end
  end

  assign hit_o   = mux_hit;
  assign pa_o    = mux_hit ? {mux_frame, lk_va_i[BASE_SHIFT-1:0]} : '0;
  assign rd_ok_o = mux_rd;
  assign wr_ok_o = mux_wr;

endmodule

// File: rtl/tlb_chk.sv
module tlb_chk #(
  parameter int unsigned N_ENTRIES = 32,
  parameter int unsigned PA_W      = 34,
  parameter int unsigned OFF_W     = 13,
  parameter int unsigned IDX_W     = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [OFF_W-1:0] off_i,
  input logic             hit_i,
  input logic             multi_i,
  input logic [PA_W-1:0]  pa_i,
  input logic             rd_i,
  input logic             wr_i,
  input logic             fill_i,
  input logic             inv_all_i,
  input logic [IDX_W-1:0] ptr_i
);

  // R8
  multi_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    multi_i |-> !hit_i);

  // R5
  miss_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_i |-> (pa_i == '0 && !rd_i && !wr_i));

  // R3
  offset_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i |-> (pa_i[OFF_W-1:0] == off_i));

  // R9
  flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_all_i |=> (!hit_i && !multi_i && ptr_i == '0));

  // R7
  ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i && !inv_all_i) |=>
      ptr_i == (($past(ptr_i) == IDX_W'(N_ENTRIES - 1)) ? '0 : $past(ptr_i) + 1'b1));

  // R7
  ptr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fill_i && !inv_all_i) |=> $stable(ptr_i));

endmodule

bind mpsz_tlb tlb_chk #(
  .N_ENTRIES (N_ENTRIES),
  .PA_W      (PA_W),
  .OFF_W     (BASE_SHIFT),
  .IDX_W     (IDX_W)
) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .off_i     (lk_va_i[BASE_SHIFT-1:0]),
  .hit_i     (hit_o),
  .multi_i   (multi_hit_o),
  .pa_i      (pa_o),
  .rd_i      (rd_ok_o),
  .wr_i      (wr_ok_o),
  .fill_i    (fill_i),
  .inv_all_i (inv_all_i),
  .ptr_i     (rr_ptr)
);

// File: tb/test_mpsz_tlb.sv
module test_mpsz_tlb;

  localparam int N  = 32;
  localparam int VA = 43;
  localparam int PA = 34;
  localparam int SH = 13;
  localparam int VW = VA - SH;
  localparam int FW = PA - SH;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [VA-1:0] lk_va = '0;
  logic          hit, multi, rd_ok, wr_ok;
  logic [PA-1:0] pa;
  logic          fill = 0, f_rd = 0, f_wr = 0, inv_one = 0, inv_all = 0;
  logic [VW-1:0] f_vpn = '0, i_vpn = '0;
  logic [FW-1:0] f_pfn = '0;
  logic [1:0]    f_size = '0;

  int n_chk = 0, n_bad = 0;

  // model state
  logic          m_valid [N];
  logic [VW-1:0] m_tag   [N];
  logic [FW-1:0] m_pfn   [N];
  logic [1:0]    m_size  [N];
  logic          m_rd    [N];
  logic          m_wr    [N];
  int            m_ptr;

  always #10 clk = ~clk;

  mpsz_tlb i_mpsz_tlb (
    .clk_i(clk), .rst_ni(rst_n), .lk_va_i(lk_va), .hit_o(hit), .multi_hit_o(multi),
    .pa_o(pa), .rd_ok_o(rd_ok), .wr_ok_o(wr_ok), .fill_i(fill), .fill_vpn_i(f_vpn),
    .fill_pfn_i(f_pfn), .fill_size_i(f_size), .fill_rd_i(f_rd), .fill_wr_i(f_wr),
    .inv_one_i(inv_one), .inv_vpn_i(i_vpn), .inv_all_i(inv_all)
  );

  function automatic logic [VA-1:0] mk_va(int hi, int lo);
    return (VA'(hi) << 22) | VA'(lo);
  endfunction

  function automatic logic m_hit_entry(int e, logic [VW-1:0] vpn);
    logic [VW-1:0] mask;
    mask = ~VW'(0) << (3 * int'(m_size[e]));
    return m_valid[e] && (((m_tag[e] ^ vpn) & mask) == '0);
  endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_outputs(string req);
    int cnt = 0, idx = 0, shift;
    logic e_hit, e_multi, e_rd, e_wr;
    logic [PA-1:0] e_pa, full, lowm;
    for (int e = 0; e < N; e++)
      if (m_hit_entry(e, lk_va[VA-1:SH])) begin cnt++; idx = e; end
    e_hit = (cnt == 1);
    e_multi = (cnt > 1);
    e_pa = '0; e_rd = 0; e_wr = 0;
    if (e_hit) begin
      shift = SH + 3 * int'(m_size[idx]);
      full  = {m_pfn[idx], SH'(0)};
      lowm  = (PA'(1) << shift) - PA'(1);
      e_pa  = (full & ~lowm) | (lk_va[PA-1:0] & lowm);
      e_rd  = m_rd[idx];
      e_wr  = m_wr[idx];
    end
    chk(req, "hit", 64'(hit), 64'(e_hit));
    chk(req, "multi", 64'(multi), 64'(e_multi));
    chk(req, "pa", 64'(pa), 64'(e_pa));
    chk(req, "rd_ok", 64'(rd_ok), 64'(e_rd));
    chk(req, "wr_ok", 64'(wr_ok), 64'(e_wr));
  endtask

  task automatic model_edge();
    if (inv_all) begin
      for (int e = 0; e < N; e++) m_valid[e] = 0;
      m_ptr = 0;
    end else begin
      if (inv_one)
        for (int e = 0; e < N; e++) if (m_hit_entry(e, i_vpn)) m_valid[e] = 0;
      if (fill) begin
        m_valid[m_ptr] = 1; m_tag[m_ptr] = f_vpn; m_pfn[m_ptr] = f_pfn;
        m_size[m_ptr] = f_size; m_rd[m_ptr] = f_rd; m_wr[m_ptr] = f_wr;
        m_ptr = (m_ptr + 1) % N;
      end
    end
  endtask

  // inputs are set at the falling edge before this is called
  task automatic cycle(string req);
    #1 check_outputs(req);
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    fill = 0; inv_one = 0; inv_all = 0;
  endtask

  task automatic do_fill(logic [VA-1:0] va, logic [FW-1:0] pfn, logic [1:0] sz,
                         logic r, logic w, string req);
    idle_inputs();
    fill = 1; f_vpn = va[VA-1:SH]; f_pfn = pfn; f_size = sz; f_rd = r; f_wr = w;
    cycle(req);
    idle_inputs();
  endtask

  task automatic look(logic [VA-1:0] va, string req);
    idle_inputs();
    lk_va = va;
    cycle(req);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=expired expected=finished");
    summary();
  end

  initial begin
    int seed;
    seed = $urandom(32'h1F2E3D4C);
    for (int e = 0; e < N; e++) begin
      m_valid[e] = 0; m_tag[e] = '0; m_pfn[e] = '0; m_size[e] = '0; m_rd[e] = 0; m_wr[e] = 0;
    end
    m_ptr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: empty after reset
    look(mk_va(0, 0), "R1");
    look(mk_va(5, 12345), "R1");
    look(~VA'(0), "R1");

    // R2 R3 R4: one entry per size, pfn low bits set to prove masking
    for (int s = 0; s < 4; s++)
      do_fill(mk_va(s + 1, 0), FW'(21'h1A5A5 + s), 2'(s), s[1], s[0], "R4");
    for (int s = 0; s < 4; s++) begin
      look(mk_va(s + 1, (1 << (SH + 3 * s)) - 1), "R3");
      look(mk_va(s + 1, 0), "R4");
      look(mk_va(s + 1, int'($urandom) & ((1 << (SH + 3 * s)) - 1)), "R3");
      look(mk_va(s + 1, 1 << (SH + 3 * s)), "R2");
      look(mk_va(s + 1, 0) ^ (VA'(1) << (SH + 3 * s)), "R5");
    end

    // R6: a fill is invisible in its own cycle
    idle_inputs();
    fill = 1; f_vpn = mk_va(9, 0) >> SH; f_pfn = 21'h00777; f_size = 2'b00; f_rd = 1; f_wr = 1;
    lk_va = mk_va(9, 3);
    cycle("R6");
    look(mk_va(9, 3), "R6");

    // R8: 4 MB page overlapping an 8 KB page
    do_fill(mk_va(12, 0), 21'h12345, 2'b11, 1, 0, "R8");
    do_fill(mk_va(12, 0), 21'h00042, 2'b00, 0, 1, "R8");
    look(mk_va(12, 5), "R8");
    look(mk_va(12, 1 << SH), "R8");

    // R10: invalidate clears both overlapping entries, same-cycle fill survives
    idle_inputs();
    inv_one = 1; i_vpn = mk_va(12, 0) >> SH;
    fill = 1; f_vpn = mk_va(13, 0) >> SH; f_pfn = 21'h0ABCD; f_size = 2'b01; f_rd = 1; f_wr = 0;
    cycle("R10");
    look(mk_va(12, 5), "R10");
    look(mk_va(12, 1 << SH), "R10");
    look(mk_va(13, 77), "R10");
    look(mk_va(9, 3), "R10");

    // R9: flush with a same-cycle fill that must be dropped
    idle_inputs();
    inv_all = 1; fill = 1; f_vpn = mk_va(14, 0) >> SH; f_pfn = 21'h1; f_size = 2'b11;
    cycle("R9");
    look(mk_va(14, 0), "R9");
    look(mk_va(13, 77), "R9");

    // R7: 33 fills from entry 0 evict the first
    for (int i = 0; i <= N; i++)
      do_fill(mk_va(20 + i, 0), FW'(i + 100), 2'b00, 1, 1, "R7");
    look(mk_va(20, 0), "R7");
    look(mk_va(21, 0), "R7");
    look(mk_va(20 + N, 8), "R7");

    // random mix
    for (int n = 0; n < 4000; n++) begin
      int r;
      idle_inputs();
      r = int'($urandom % 100);
      lk_va = mk_va(int'($urandom % 4), int'($urandom % (1 << 22)));
      if (r < 30) begin
        fill = 1; f_vpn = mk_va(int'($urandom % 4), int'($urandom % (1 << 22))) >> SH;
        f_pfn = FW'($urandom); f_size = 2'($urandom); f_rd = 1'($urandom); f_wr = 1'($urandom);
      end
      if (r >= 30 && r < 36) begin
        inv_one = 1; i_vpn = mk_va(int'($urandom % 4), int'($urandom % (1 << 22))) >> SH;
      end
      if (r == 99) inv_all = 1;
      cycle("R2 R3 R4 R7 R8 R10");
    end
    idle_inputs();
    summary();
  end

endmodule